// File: doc/BRIEF.md
# Three-Tier Interrupt Status Resolver

This block gathers interrupt request lines from three groups and reduces them to one status word and one vector. The groups are critical (four code slots), main (seventeen sources) and peripheral (thirty-two sources). Main and peripheral requests pass through per-source mask registers first. Critical requests are never masked. Within each group the lowest-numbered live request wins. Each group reports a pending flag and its winning source code in a fixed field of the status word.

A peripheral source can be raised to a higher tier by a per-source boost flag. A high boost makes it appear as a reserved code in the critical field. A low boost makes it appear as a reserved code in the main field. The block also forms a single vector for the interrupt that should be serviced next. The critical group beats the main group, and the main group beats the peripheral group. The vector is a 2-bit group number placed above a 6-bit source number. When the winning field holds a reserved boost code, the vector is taken from the peripheral field instead.

Both the status word and the vector are registered. They reflect the request lines, boost flags and masks sampled at the previous rising clock edge. A simple one-word write port loads either mask register.

Top module: `irq_tier_resolver`

## Requirements
- R1: During and after a synchronous active-low reset, the outputs hold the following values:
  - main mask: 0x00010FFF;
  - peripheral mask: 0x7FFFFC00;
  - status word: 0;
  - vector: 0;
  - valid: 0.
- R2: A mask write loads its value at the clock edge, and the mask outputs show it from the next cycle. With `cfg_sel_i`=0 the main mask takes bits 16:0 of `cfg_wdata_i`, and its output reads zero in bits 31:17. With `cfg_sel_i`=1 the peripheral mask takes all 32 bits. Without `cfg_we_i` both masks hold their values.
- R3: Main source n is live only when bit 16-n of the main mask is 0. Peripheral source n is live only when bit 31-n of the peripheral mask is 0. A request on a masked source changes neither the status word nor the vector.
- R4: Status bit 10 is the critical pending flag and bits 9:8 hold the critical code. The code is the lowest slot that is active. Slots 0, 1 and 3 follow `crit_req_i`. Slot 2 is active when any live peripheral source is high-boosted. Request line 2 of `crit_req_i` is ignored. Status bits outside the three fields are always 0.
- R5: Status bit 21 is the main pending flag and bits 20:16 hold the main code. The code is the lowest slot that is active among live main sources, excluding source 4. Slot 4 is active when any live peripheral source is low-boosted. Request line 4 of `main_req_i` is ignored.
- R6: Status bit 29 is the peripheral pending flag and bits 28:24 hold the peripheral code. A source is high-boosted when its `boost_hi_i` bit is 1. It is low-boosted when its `boost_lo_i` bit is 1 and its `boost_hi_i` bit is 0. The code is chosen as follows:
  - the lowest live high-boosted source, if there is one;
  - otherwise the lowest live low-boosted source, if there is one;
  - otherwise the lowest live source.
- R7: The vector is (group << 6) | code, with group 0 for critical, 1 for main and 2 for peripheral. It is taken from the critical field if that field is pending. Otherwise it is taken from the main field if that is pending. Otherwise it is taken from the peripheral field.
- R8: A winning critical code of 2, or a winning main code of 4, produces the vector 0x80 | peripheral code.
- R9: When no field is pending, the three pending flags are 0, `vec_valid_o` is 0 and the vector is 0. Otherwise `vec_valid_o` is 1.
- R10: The status word, vector and valid flag change only at a rising clock edge. They reflect the inputs and masks from just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Mask write strobe |
| cfg_sel_i | input | 1 | Mask select: 0 main, 1 peripheral |
| cfg_wdata_i | input | 32 | Mask write value |
| crit_req_i | input | 4 | Critical request lines (line 2 ignored) |
| main_req_i | input | 17 | Main request lines (line 4 ignored) |
| per_req_i | input | 32 | Peripheral request lines |
| boost_hi_i | input | 32 | Per peripheral source: raise to critical tier |
| boost_lo_i | input | 32 | Per peripheral source: raise to main tier |
| main_mask_o | output | 32 | Current main mask |
| per_mask_o | output | 32 | Current peripheral mask |
| status_o | output | 32 | Encoded status word |
| vec_o | output | 8 | Highest-priority vector |
| vec_valid_o | output | 1 | Vector is meaningful |

## Verification
The same cycle can carry a genuine critical or main request and a boosted peripheral request, which then compete for the one code in that field. It can also carry a boost redirection and a lower-numbered ordinary source in the same tier. The bench provokes these collisions in two ways: single-source sweeps under each boost mode, and a long run of sparse random request, boost and mask patterns. It judges every cycle against an arithmetic model built from the requirements. That model derives each field's code and the redirected vector independently of the design.

// File: rtl/irq_tier_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes, status-word field positions, reserved codes and
// reset values for the three-tier interrupt status resolver.
package irq_tier_pkg;

    localparam int CRIT_N = 4;
    localparam int MAIN_N = 17;
    localparam int PER_N  = 32;
    localparam int WORD_W = 32;
    localparam int SRC_W  = 6;
    localparam int GRP_W  = 2;
    localparam int VEC_W  = GRP_W + SRC_W;

    // Status-word layout (decoded by the consumer, so positions are fixed)
    localparam int CRIT_PEND_BIT = 10;
    localparam int CRIT_CODE_LSB = 8;
    localparam int CRIT_CODE_W   = 2;
    localparam int MAIN_PEND_BIT = 21;
    localparam int MAIN_CODE_LSB = 16;
    localparam int MAIN_CODE_W   = 5;
    localparam int PER_PEND_BIT  = 29;
    localparam int PER_CODE_LSB  = 24;
    localparam int PER_CODE_W    = 5;

    // Reserved codes that stand for boosted peripheral requests
    localparam int CRIT_BOOST_CODE = 2;
    localparam int MAIN_BOOST_CODE = 4;

    localparam logic [WORD_W-1:0] MAIN_MASK_RST = 32'h0001_0FFF;
    localparam logic [WORD_W-1:0] PER_MASK_RST  = 32'h7FFF_FC00;

    // Bits of the status word that belong to some field
    localparam logic [WORD_W-1:0] STATUS_USED =
        (WORD_W'(1) << CRIT_PEND_BIT) | (WORD_W'((1 << CRIT_CODE_W) - 1) << CRIT_CODE_LSB) |
        (WORD_W'(1) << MAIN_PEND_BIT) | (WORD_W'((1 << MAIN_CODE_W) - 1) << MAIN_CODE_LSB) |
        (WORD_W'(1) << PER_PEND_BIT)  | (WORD_W'((1 << PER_CODE_W) - 1) << PER_CODE_LSB);

    typedef enum logic [GRP_W-1:0] {
        GRP_CRIT = 2'd0,
        GRP_MAIN = 2'd1,
        GRP_PER  = 2'd2
    } grp_e;

    typedef struct packed {
        logic             pend;
        logic [SRC_W-1:0] code;
    } tier_field_t;

endpackage

// File: rtl/irq_lowest_pick.sv
`timescale 1ns/1ps
// Module: irq_lowest_pick
// Finds the lowest-numbered asserted bit of a request vector.
// Assumes: purely combinational; idx_o is 0 when nothing is asserted.
module irq_lowest_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    // Scan from the top down so the lowest asserted index is the last write
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
// Module: irq_mask_bank
// Holds the main and peripheral mask registers, loaded one word at a time,
// and turns them into per-source enables in source-index order.
// Assumes: mask bit (COUNT-1-n) gates source n; a 1 disables the source.
module irq_mask_bank #(
    parameter int                MAIN_CNT = irq_tier_pkg::MAIN_N,
    parameter int                PER_CNT  = irq_tier_pkg::PER_N,
    parameter int                WORD_W   = irq_tier_pkg::WORD_W,
    parameter logic [WORD_W-1:0] MAIN_RST = irq_tier_pkg::MAIN_MASK_RST,
    parameter logic [WORD_W-1:0] PER_RST  = irq_tier_pkg::PER_MASK_RST
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                we_i,
    input  logic                sel_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic [WORD_W-1:0]   main_mask_o,
    output logic [WORD_W-1:0]   per_mask_o,
    output logic [MAIN_CNT-1:0] main_en_o,
    output logic [PER_CNT-1:0]  per_en_o
);

    logic [MAIN_CNT-1:0] main_q;
    logic [PER_CNT-1:0]  per_q;

    // Mask registers: reset to the disabled pattern, load on a write strobe
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            main_q <= MAIN_RST[MAIN_CNT-1:0];
            per_q  <= PER_RST[PER_CNT-1:0];
        end else if (we_i) begin
            if (sel_i) begin
                per_q <= wdata_i[PER_CNT-1:0];
            end else begin
                main_q <= wdata_i[MAIN_CNT-1:0];
            end
        end
    end

    assign main_mask_o = WORD_W'(main_q);
    assign per_mask_o  = WORD_W'(per_q);

    // Reverse the bit order: source n is gated by mask bit COUNT-1-n
    for (genvar n = 0; n < MAIN_CNT; n++) begin : g_main_en
        assign main_en_o[n] = ~main_q[MAIN_CNT-1-n];
    end
    for (genvar n = 0; n < PER_CNT; n++) begin : g_per_en
        assign per_en_o[n] = ~per_q[PER_CNT-1-n];
    end

    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> ($stable(main_q) && $stable(per_q)))
        else $error("mask changed without a write"); // R2

    AST_MAIN_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && !sel_i) |=> (main_q == $past(wdata_i[MAIN_CNT-1:0])) && $stable(per_q))
        else $error("main mask write not taken"); // R2

endmodule

// File: rtl/irq_tier_encode.sv
`timescale 1ns/1ps
// Module: irq_tier_encode
// Builds the critical, main and peripheral fields from the request lines,
// the mask enables and the boost flags.
// Assumes: a boost-high flag overrides a boost-low flag on the same source;
// reserved codes replace the request lines that share their slot.
module irq_tier_encode
    import irq_tier_pkg::*;
#(
    parameter int CRIT_CNT   = CRIT_N,
    parameter int MAIN_CNT   = MAIN_N,
    parameter int PER_CNT    = PER_N,
    parameter int CRIT_BOOST = CRIT_BOOST_CODE,
    parameter int MAIN_BOOST = MAIN_BOOST_CODE
) (
    input  logic [CRIT_CNT-1:0] crit_req_i,
    input  logic [MAIN_CNT-1:0] main_req_i,
    input  logic [MAIN_CNT-1:0] main_en_i,
    input  logic [PER_CNT-1:0]  per_req_i,
    input  logic [PER_CNT-1:0]  per_en_i,
    input  logic [PER_CNT-1:0]  boost_hi_i,
    input  logic [PER_CNT-1:0]  boost_lo_i,
    output tier_field_t         crit_f_o,
    output tier_field_t         main_f_o,
    output tier_field_t         per_f_o
);

    localparam int CRIT_IW = (CRIT_CNT > 1) ? $clog2(CRIT_CNT) : 1;
    localparam int MAIN_IW = (MAIN_CNT > 1) ? $clog2(MAIN_CNT) : 1;
    localparam int PER_IW  = (PER_CNT > 1) ? $clog2(PER_CNT) : 1;
    localparam int CLS_N   = 3; // 0 high-boosted, 1 low-boosted, 2 ordinary

    logic [PER_CNT-1:0]  per_live;
    logic [PER_CNT-1:0]  class_vec [CLS_N];
    logic [CLS_N-1:0]    class_found;
    logic [PER_IW-1:0]   class_idx [CLS_N];
    logic [CRIT_CNT-1:0] crit_cand;
    logic [MAIN_CNT-1:0] main_cand;
    logic                crit_found;
    logic [CRIT_IW-1:0]  crit_idx;
    logic                main_found;
    logic [MAIN_IW-1:0]  main_idx;
    logic [PER_IW-1:0]   per_idx;

    // Split the live peripheral requests into the three boost classes
    always_comb begin
        per_live     = per_req_i & per_en_i;
        class_vec[0] = per_live & boost_hi_i;
        class_vec[1] = per_live & boost_lo_i & ~boost_hi_i;
        class_vec[2] = per_live & ~boost_lo_i & ~boost_hi_i;
    end

    for (genvar c = 0; c < CLS_N; c++) begin : g_cls_pick
        irq_lowest_pick #(.N(PER_CNT), .IW(PER_IW)) u_cls_pick (
            .req_i   (class_vec[c]),
            .found_o (class_found[c]),
            .idx_o   (class_idx[c])
        );
    end

    // Peripheral code: boosted-high first, then boosted-low, then ordinary
    always_comb begin
        if (class_found[0]) begin
            per_idx = class_idx[0];
        end else if (class_found[1]) begin
            per_idx = class_idx[1];
        end else begin
            per_idx = class_idx[2];
        end
    end

    // Candidate slots: reserved slots carry the boosted-peripheral presence
    always_comb begin
        crit_cand             = crit_req_i;
        crit_cand[CRIT_BOOST] = class_found[0];
        main_cand             = main_req_i & main_en_i;
        main_cand[MAIN_BOOST] = class_found[1];
    end

    irq_lowest_pick #(.N(CRIT_CNT), .IW(CRIT_IW)) u_crit_pick (
        .req_i   (crit_cand),
        .found_o (crit_found),
        .idx_o   (crit_idx)
    );

    irq_lowest_pick #(.N(MAIN_CNT), .IW(MAIN_IW)) u_main_pick (
        .req_i   (main_cand),
        .found_o (main_found),
        .idx_o   (main_idx)
    );

    // Pack each group's winner into its field
    always_comb begin
        crit_f_o.pend = crit_found;
        crit_f_o.code = SRC_W'(crit_idx);
        main_f_o.pend = main_found;
        main_f_o.code = SRC_W'(main_idx);
        per_f_o.pend  = |class_found;
        per_f_o.code  = SRC_W'(per_idx);
    end

endmodule

// File: rtl/irq_vector_resolve.sv
`timescale 1ns/1ps
// Module: irq_vector_resolve
// Packs the three fields into the status word and selects the single
// highest-priority vector, following reserved codes to the peripheral field.
// Assumes: a reserved code is only present while the peripheral field is pending.
module irq_vector_resolve
    import irq_tier_pkg::*;
#(
    parameter int CRIT_BOOST = CRIT_BOOST_CODE,
    parameter int MAIN_BOOST = MAIN_BOOST_CODE
) (
    input  tier_field_t       crit_f_i,
    input  tier_field_t       main_f_i,
    input  tier_field_t       per_f_i,
    output logic [WORD_W-1:0] status_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              valid_o
);

    logic crit_redirect;
    logic main_redirect;

    // Place each field at its fixed position; all other bits stay zero
    always_comb begin
        status_o = '0;
        status_o[CRIT_PEND_BIT]                 = crit_f_i.pend;
        status_o[CRIT_CODE_LSB +: CRIT_CODE_W]  = crit_f_i.code[CRIT_CODE_W-1:0];
        status_o[MAIN_PEND_BIT]                 = main_f_i.pend;
        status_o[MAIN_CODE_LSB +: MAIN_CODE_W]  = main_f_i.code[MAIN_CODE_W-1:0];
        status_o[PER_PEND_BIT]                  = per_f_i.pend;
        status_o[PER_CODE_LSB +: PER_CODE_W]    = per_f_i.code[PER_CODE_W-1:0];
    end

    assign crit_redirect = (crit_f_i.code == SRC_W'(CRIT_BOOST));
    assign main_redirect = (main_f_i.code == SRC_W'(MAIN_BOOST));

    // Fixed group order, with reserved codes deferring to the peripheral field
    always_comb begin
        valid_o = 1'b1;
        if (crit_f_i.pend) begin
            vec_o = crit_redirect ? {GRP_PER, per_f_i.code} : {GRP_CRIT, crit_f_i.code};
        end else if (main_f_i.pend) begin
            vec_o = main_redirect ? {GRP_PER, per_f_i.code} : {GRP_MAIN, main_f_i.code};
        end else if (per_f_i.pend) begin
            vec_o = {GRP_PER, per_f_i.code};
        end else begin
            vec_o   = '0;
            valid_o = 1'b0;
        end
    end

endmodule

// File: rtl/irq_tier_resolver.sv
`timescale 1ns/1ps
// Module: irq_tier_resolver (top)
// Three-tier interrupt status resolver: masks, group encoding, vector
// selection and the output registers.
// Assumes: request and boost lines are synchronous to clk_i; outputs are
// registered, so they lag the inputs by one clock.
module irq_tier_resolver
    import irq_tier_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                cfg_we_i,
    input  logic                cfg_sel_i,
    input  logic [WORD_W-1:0]   cfg_wdata_i,
    input  logic [CRIT_N-1:0]   crit_req_i,
    input  logic [MAIN_N-1:0]   main_req_i,
    input  logic [PER_N-1:0]    per_req_i,
    input  logic [PER_N-1:0]    boost_hi_i,
    input  logic [PER_N-1:0]    boost_lo_i,
    output logic [WORD_W-1:0]   main_mask_o,
    output logic [WORD_W-1:0]   per_mask_o,
    output logic [WORD_W-1:0]   status_o,
    output logic [VEC_W-1:0]    vec_o,
    output logic                vec_valid_o
);

    logic [MAIN_N-1:0] main_en;
    logic [PER_N-1:0]  per_en;
    tier_field_t       crit_f;
    tier_field_t       main_f;
    tier_field_t       per_f;
    logic [WORD_W-1:0] status_d;
    logic [VEC_W-1:0]  vec_d;
    logic              valid_d;
    logic [WORD_W-1:0] status_q;
    logic [VEC_W-1:0]  vec_q;
    logic              valid_q;

    irq_mask_bank #(
        .MAIN_CNT (MAIN_N),
        .PER_CNT  (PER_N),
        .WORD_W   (WORD_W),
        .MAIN_RST (MAIN_MASK_RST),
        .PER_RST  (PER_MASK_RST)
    ) u_masks (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (cfg_we_i),
        .sel_i       (cfg_sel_i),
        .wdata_i     (cfg_wdata_i),
        .main_mask_o (main_mask_o),
        .per_mask_o  (per_mask_o),
        .main_en_o   (main_en),
        .per_en_o    (per_en)
    );

    irq_tier_encode #(
        .CRIT_CNT   (CRIT_N),
        .MAIN_CNT   (MAIN_N),
        .PER_CNT    (PER_N),
        .CRIT_BOOST (CRIT_BOOST_CODE),
        .MAIN_BOOST (MAIN_BOOST_CODE)
    ) u_encode (
        .crit_req_i (crit_req_i),
        .main_req_i (main_req_i),
        .main_en_i  (main_en),
        .per_req_i  (per_req_i),
        .per_en_i   (per_en),
        .boost_hi_i (boost_hi_i),
        .boost_lo_i (boost_lo_i),
        .crit_f_o   (crit_f),
        .main_f_o   (main_f),
        .per_f_o    (per_f)
    );

    irq_vector_resolve #(
        .CRIT_BOOST (CRIT_BOOST_CODE),
        .MAIN_BOOST (MAIN_BOOST_CODE)
    ) u_resolve (
        .crit_f_i (crit_f),
        .main_f_i (main_f),
        .per_f_i  (per_f),
        .status_o (status_d),
        .vec_o    (vec_d),
        .valid_o  (valid_d)
    );

    // Output registers: clear on reset, otherwise capture this cycle's result
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            status_q <= '0;
            vec_q    <= '0;
            valid_q  <= 1'b0;
        end else begin
            status_q <= status_d;
            vec_q    <= vec_d;
            valid_q  <= valid_d;
        end
    end

    assign status_o    = status_q;
    assign vec_o       = vec_q;
    assign vec_valid_o = valid_q;

    // One-hot of the registered main code, used to look up its enable
    logic [MAIN_N-1:0] main_code_oh;
    assign main_code_oh = MAIN_N'(1) << status_q[MAIN_CODE_LSB +: MAIN_CODE_W];

    AST_VALID_TRACKS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_valid_o == (status_o[CRIT_PEND_BIT] | status_o[MAIN_PEND_BIT] | status_o[PER_PEND_BIT]))
        else $error("valid disagrees with pending flags"); // R9

    AST_IDLE_VEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vec_valid_o |-> (vec_o == '0))
        else $error("vector not zero while idle"); // R9

    AST_GROUP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_valid_o |-> (vec_o[VEC_W-1 -: GRP_W] != 2'd3))
        else $error("vector carries an unused group"); // R7

    AST_CRIT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[CRIT_PEND_BIT] && status_o[CRIT_CODE_LSB +: CRIT_CODE_W] != CRIT_CODE_W'(CRIT_BOOST_CODE))
        |-> (vec_o == VEC_W'(status_o[CRIT_CODE_LSB +: CRIT_CODE_W])))
        else $error("critical request did not win"); // R7

    AST_CRIT_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[CRIT_PEND_BIT] && status_o[CRIT_CODE_LSB +: CRIT_CODE_W] == CRIT_CODE_W'(CRIT_BOOST_CODE))
        |-> (status_o[PER_PEND_BIT] && vec_o == {GRP_PER, 1'b0, status_o[PER_CODE_LSB +: PER_CODE_W]}))
        else $error("boosted-high redirect missed"); // R8

    AST_MAIN_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!status_o[CRIT_PEND_BIT] && status_o[MAIN_PEND_BIT] &&
         status_o[MAIN_CODE_LSB +: MAIN_CODE_W] == MAIN_CODE_W'(MAIN_BOOST_CODE))
        |-> (status_o[PER_PEND_BIT] && vec_o == {GRP_PER, 1'b0, status_o[PER_CODE_LSB +: PER_CODE_W]}))
        else $error("boosted-low redirect missed"); // R8

    AST_SPARE_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o & ~STATUS_USED) == '0)
        else $error("status bit outside a field set"); // R4

    AST_MAIN_SRC_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o[MAIN_PEND_BIT] && status_o[MAIN_CODE_LSB +: MAIN_CODE_W] != MAIN_CODE_W'(MAIN_BOOST_CODE))
        |-> (($past(main_en) & main_code_oh) != '0))
        else $error("masked main source reported"); // R3

endmodule

// File: tb/irq_tier_resolver_tb_top.sv
`timescale 1ns/1ps
// Bench for irq_tier_resolver: directed sweeps over every source plus a
// long sparse random run, each cycle checked against an arithmetic model.
module irq_tier_resolver_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  crit = '0;
    logic [16:0] mreq = '0;
    logic [31:0] preq = '0;
    logic [31:0] bhi = '0;
    logic [31:0] blo = '0;
    logic [31:0] main_mask;
    logic [31:0] per_mask;
    logic [31:0] status;
    logic [7:0]  vec;
    logic        vld;

    logic [31:0] exp_mmask = 32'h0001_0FFF;
    logic [31:0] exp_pmask = 32'h7FFF_FC00;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    irq_tier_resolver dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (cfg_we),
        .cfg_sel_i   (cfg_sel),
        .cfg_wdata_i (cfg_wdata),
        .crit_req_i  (crit),
        .main_req_i  (mreq),
        .per_req_i   (preq),
        .boost_hi_i  (bhi),
        .boost_lo_i  (blo),
        .main_mask_o (main_mask),
        .per_mask_o  (per_mask),
        .status_o    (status),
        .vec_o       (vec),
        .vec_valid_o (vld)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Expected outputs derived from the requirements
    function automatic void model(output logic [31:0] st, output logic [7:0] v, output logic vl);
        int hi = -1;
        int lo = -1;
        int nm = -1;
        int pc;
        int cc = -1;
        int mc = -1;
        for (int n = 0; n < 32; n++) begin
            if (preq[n] && !exp_pmask[31-n]) begin
                if (bhi[n]) begin
                    if (hi < 0) hi = n;
                end else if (blo[n]) begin
                    if (lo < 0) lo = n;
                end else if (nm < 0) begin
                    nm = n;
                end
            end
        end
        pc = (hi >= 0) ? hi : ((lo >= 0) ? lo : nm);
        for (int c = 3; c >= 0; c--) begin
            if ((c == 2) ? (hi >= 0) : crit[c]) cc = c;
        end
        for (int n = 16; n >= 0; n--) begin
            if ((n == 4) ? (lo >= 0) : (mreq[n] && !exp_mmask[16-n])) mc = n;
        end
        st = '0;
        if (cc >= 0) st = st | 32'h0000_0400 | (32'(cc) << 8);
        if (mc >= 0) st = st | 32'h0020_0000 | (32'(mc) << 16);
        if (pc >= 0) st = st | 32'h2000_0000 | (32'(pc) << 24);
        vl = 1'b1;
        if (cc >= 0)      v = (cc == 2) ? (8'h80 | 8'(pc)) : 8'(cc);
        else if (mc >= 0) v = (mc == 4) ? (8'h80 | 8'(pc)) : (8'h40 | 8'(mc));
        else if (pc >= 0) v = 8'h80 | 8'(pc);
        else begin
            v  = 8'h00;
            vl = 1'b0;
        end
    endfunction

    // Called right after a negedge with new inputs set: cross one edge, compare
    task automatic step(input string tag);
        logic [31:0] st;
        logic [7:0]  v;
        logic        vl;
        @(negedge clk);
        model(st, v, vl);
        chk({tag, " status"}, status, st);
        chk({tag, " vector"}, 32'(vec), 32'(v));
        chk({tag, " valid"}, 32'(vld), 32'(vl));
    endtask

    task automatic write_mask(input logic sel, input logic [31:0] data);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) exp_pmask = data;
        else     exp_mmask = data & 32'h0001_FFFF;
        chk("R2 main mask", main_mask, exp_mmask);
        chk("R2 per mask", per_mask, exp_pmask);
    endtask

    task automatic clear_inputs();
        crit = '0; mreq = '0; preq = '0; bhi = '0; blo = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R10 watchdog act=running exp=done");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        chk("R1 main mask", main_mask, 32'h0001_0FFF);
        chk("R1 per mask", per_mask, 32'h7FFF_FC00);
        chk("R1 status", status, 32'h0);
        chk("R1 vector", 32'(vec), 32'h0);
        chk("R1 valid", 32'(vld), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 with reset masks: main 5 and peripheral 3 are disabled
        mreq = 17'h00020; preq = 32'h0000_0008;
        step("R3 reset-masked sources");
        clear_inputs();

        // R2: main write drops upper bits; then enable everything
        write_mask(1'b0, 32'hFFFF_FFFF);
        write_mask(1'b0, 32'h0);
        write_mask(1'b1, 32'h0);

        // R10: outputs wait for the edge
        crit = 4'b0001;
        #1;
        chk("R10 before edge status", status, 32'h0);
        chk("R10 before edge valid", 32'(vld), 32'h0);
        step("R10 after edge");
        clear_inputs();
        step("R9 idle");

        // R4: each critical line alone (line 2 ignored)
        for (int c = 0; c < 4; c++) begin
            crit = 4'(1 << c);
            step("R4 critical single");
        end
        clear_inputs();

        // R5: each main line alone (line 4 ignored)
        for (int n = 0; n < 17; n++) begin
            mreq = 17'(1 << n);
            step("R5 main single");
        end
        clear_inputs();

        // R6/R8: each peripheral source under each boost mode, with competitors
        for (int mode = 0; mode < 3; mode++) begin
            bhi = (mode == 1) ? 32'hFFFF_FFFF : 32'h0;
            blo = (mode == 2) ? 32'hFFFF_FFFF : 32'h0;
            for (int n = 0; n < 32; n++) begin
                preq = 32'(1) << n;
                crit = 4'b1000; mreq = 17'h00008;
                step("R6/R8 peripheral boost");
                crit = 4'b0000; mreq = 17'h0;
                step("R6/R8 peripheral alone");
            end
        end
        clear_inputs();

        // R3: mask one source at a time with every line requesting
        for (int n = 0; n < 17; n++) begin
            write_mask(1'b0, 32'(1) << (16 - n));
            mreq = 17'h1FFFF;
            step("R3 main mask sweep");
            mreq = '0;
        end
        write_mask(1'b0, 32'h0);
        for (int n = 0; n < 32; n++) begin
            write_mask(1'b1, 32'(1) << (31 - n));
            preq = 32'(1) << n;
            step("R3 per masked alone");
            preq = 32'hFFFF_FFFF;
            step("R3 per mask sweep");
            preq = '0;
        end

        // R7/R8: sparse random mixes with occasional mask changes
        for (int it = 0; it < 3000; it++) begin
            if (it % 64 == 0) begin
                write_mask(1'b0, $urandom & $urandom);
                write_mask(1'b1, $urandom & $urandom);
            end
            crit = 4'($urandom & $urandom);
            mreq = 17'($urandom & $urandom & $urandom);
            preq = $urandom & $urandom & $urandom;
            bhi  = $urandom & $urandom & $urandom;
            blo  = $urandom & $urandom;
            step("R7/R8 random");
        end
        clear_inputs();
        step("R9 idle at end");

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule